// File: doc/BRIEF.md
# Mixed-Reliability Way Allocation Controller

This block makes the placement decisions for a set-associative cache whose ways come in two kinds. A small group of ways is built from large cells that keep their data at low supply voltage. The remaining ways use small cells that may flip bits at low voltage. Modified data has no other copy in the memory hierarchy, so it must only ever sit in the robust group. Clean data can be fetched again after an error, so it goes into the fragile group. On a miss, the controller uses the request kind to pick the class. It then picks a victim inside that class and writes back that victim first if it holds modified data. It then announces the fill.

The controller holds the valid bit, the dirty bit and the recency order for every way of every set. Each class keeps its own recency order, stored as one age counter per way. With two robust ways this is a single order bit. Hits are reported to the block so that it can refresh recency. It does not handle the data arrays, the tag compare, the memory interface or write hits that land in fragile ways.

Top module: `mrw_alloc_ctrl`

## Requirements
- R1: A write miss (req_kind = 1) fills a robust way, index 0 to N_ROB-1 (0 or 1 by default), with fill_dirty = 1.
- R2: A read miss (req_kind = 0) fills a fragile way, index N_ROB to N_ROB+N_FRG-1 (2 to 7 by default), with fill_dirty = 0.
- R3: If the target class of the set has an invalid way, the lowest-indexed invalid way of that class is the victim.
- R4: If every way of the target class is valid, the victim is the least recently used way of that class. Only fills and hits inside a class change that class's recency.
- R5: A read hit (req_kind = 2) leaves the valid and dirty bits unchanged and makes the hit way the most recent of its class.
- R6: A write hit (req_kind = 3) on a robust way marks it dirty and most recent. A write hit on a fragile way has no effect on any state.
- R7: A victim that is valid and dirty raises wb_req with wb_way = victim index in the cycle after the miss is accepted. wb_req and wb_way hold until wb_ack is sampled high. The fill pulse follows in the next cycle.
- R8: A victim that is invalid or clean produces no writeback. fill_valid is high for exactly one cycle, starting in the cycle after the miss is accepted.
- R9: After reset, req_ready = 1, wb_req = 0, fill_valid = 0, and every way is invalid. req_ready is low from miss acceptance until the fill pulse ends, and a request offered then is ignored.
- R10: The state of each set is independent of every other set, and fill_set reports the missing set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 read hit, 3 write hit |
| req_set | input | SW | Set index of the request |
| req_way | input | WW | Hit way (hits only) |
| req_ready | output | 1 | Controller can accept a request |
| wb_req | output | 1 | Writeback of dirty victim requested |
| wb_way | output | WW | Way to write back |
| wb_ack | input | 1 | Writeback accepted |
| fill_valid | output | 1 | One-cycle fill announcement |
| fill_set | output | SW | Set being filled |
| fill_way | output | WW | Way receiving the new line |
| fill_dirty | output | 1 | New line is modified |

## Verification
Read misses first fill a set's fragile ways from empty. This separates invalid-first choice from recency choice. Write misses then fill the robust pair and force dirty evictions, so the class split and the writeback handshake are both exercised, including a delayed acknowledge and a request offered while busy. Read hits and write hits placed before a miss change which way must be evicted. A hit that wrongly refreshes, or wrongly fails to refresh, a way's recency therefore shows up as a different victim. A second set and the last set are filled while set 0 is full, to separate per-set state from shared state.

// File: rtl/mrw_pkg.sv
package mrw_pkg;

    localparam int unsigned DEF_N_ROB = 2;
    localparam int unsigned DEF_N_FRG = 6;
    localparam int unsigned DEF_SETS  = 16;

    typedef enum logic [1:0] {
        K_RD_MISS = 2'd0,
        K_WR_MISS = 2'd1,
        K_RD_HIT  = 2'd2,
        K_WR_HIT  = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WB   = 2'd1,
        S_FILL = 2'd2
    } fill_state_e;

    typedef struct packed {
        logic is_wr;
        logic need_wb;
    } miss_flags_t;

    function automatic logic kind_is_miss(req_kind_e k);
        return (k == K_RD_MISS) || (k == K_WR_MISS);
    endfunction

endpackage

// File: rtl/mrw_class_pick.sv
module mrw_class_pick #(
    parameter int unsigned N  = 2,
    parameter int unsigned AW = (N > 1) ? $clog2(N) : 1,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    valid,
    input  logic [N*AW-1:0] ages,
    output logic [IW-1:0]   pick
);
    logic [AW-1:0] best_age;

    always_comb begin
        pick     = '0;
        best_age = ages[AW-1:0];
        for (int i = 1; i < N; i++) begin
            if (ages[i*AW +: AW] > best_age) begin
                best_age = ages[i*AW +: AW];
                pick     = IW'(i);
            end
        end
        // lowest invalid way overrides the recency choice
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) pick = IW'(i);
        end
    end
endmodule

// File: rtl/mrw_fill_fsm.sv
module mrw_fill_fsm
    import mrw_pkg::*;
#(
    parameter int unsigned SW = 4,
    parameter int unsigned WW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [SW-1:0] start_set,
    input  logic [WW-1:0] start_way,
    input  miss_flags_t   start_flags,
    input  logic          wb_ack,
    output logic          busy,
    output logic          wb_req,
    output logic [WW-1:0] wb_way,
    output logic          fill_valid,
    output logic [SW-1:0] fill_set,
    output logic [WW-1:0] fill_way,
    output logic          fill_dirty
);
    fill_state_e   st_q;
    logic [SW-1:0] set_q;
    logic [WW-1:0] way_q;
    miss_flags_t   flg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            set_q <= '0;
            way_q <= '0;
            flg_q <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: if (start) begin
                    set_q <= start_set;
                    way_q <= start_way;
                    flg_q <= start_flags;
                    st_q  <= start_flags.need_wb ? S_WB : S_FILL;
                end
                S_WB:   if (wb_ack) st_q <= S_FILL;
                S_FILL: st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign busy       = (st_q != S_IDLE);
    assign wb_req     = (st_q == S_WB);
    assign wb_way     = way_q;
    assign fill_valid = (st_q == S_FILL);
    assign fill_set   = set_q;
    assign fill_way   = way_q;
    assign fill_dirty = flg_q.is_wr;

    a_r7_wb_held: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_way)));
    a_r7_fill_after_ack: assert property (@(posedge clk) disable iff (rst)
        (wb_req && wb_ack) |=> fill_valid);
    a_r8_fill_one_cycle: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> !fill_valid);
endmodule

// File: rtl/mrw_alloc_ctrl.sv
module mrw_alloc_ctrl
    import mrw_pkg::*;
#(
    parameter int unsigned N_ROB = DEF_N_ROB,
    parameter int unsigned N_FRG = DEF_N_FRG,
    parameter int unsigned SETS  = DEF_SETS,
    localparam int unsigned WAYS = N_ROB + N_FRG,
    localparam int unsigned WW   = $clog2(WAYS),
    localparam int unsigned SW   = $clog2(SETS),
    localparam int unsigned RAW  = $clog2(N_ROB),
    localparam int unsigned FAW  = $clog2(N_FRG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [SW-1:0] req_set,
    input  logic [WW-1:0] req_way,
    output logic          req_ready,
    output logic          wb_req,
    output logic [WW-1:0] wb_way,
    input  logic          wb_ack,
    output logic          fill_valid,
    output logic [SW-1:0] fill_set,
    output logic [WW-1:0] fill_way,
    output logic          fill_dirty
);
    logic [WAYS-1:0]      vld_q  [SETS];
    logic [WAYS-1:0]      dty_q  [SETS];
    logic [N_ROB*RAW-1:0] rage_q [SETS];
    logic [N_FRG*FAW-1:0] fage_q [SETS];

    req_kind_e   kind;
    logic        accept, busy, start, way_rob;
    logic [RAW-1:0] rob_pick;
    logic [FAW-1:0] frg_pick;
    logic [WW-1:0]  victim;
    miss_flags_t    flags;

    assign kind      = req_kind_e'(req_kind);
    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign start     = accept && kind_is_miss(kind);
    assign way_rob   = (req_way < WW'(N_ROB));

    mrw_class_pick #(.N(N_ROB), .AW(RAW)) u_rob_pick (
        .valid (vld_q[req_set][N_ROB-1:0]),
        .ages  (rage_q[req_set]),
        .pick  (rob_pick)
    );

    mrw_class_pick #(.N(N_FRG), .AW(FAW)) u_frg_pick (
        .valid (vld_q[req_set][WAYS-1:N_ROB]),
        .ages  (fage_q[req_set]),
        .pick  (frg_pick)
    );

    always_comb begin
        flags.is_wr   = (kind == K_WR_MISS);
        victim        = flags.is_wr ? WW'(rob_pick) : WW'(N_ROB) + WW'(frg_pick);
        flags.need_wb = vld_q[req_set][victim] && dty_q[req_set][victim];
    end

    mrw_fill_fsm #(.SW(SW), .WW(WW)) u_fsm (
        .clk, .rst,
        .start       (start),
        .start_set   (req_set),
        .start_way   (victim),
        .start_flags (flags),
        .wb_ack,
        .busy,
        .wb_req, .wb_way,
        .fill_valid, .fill_set, .fill_way, .fill_dirty
    );

    // recency / status update: one source per cycle (hits only while idle)
    logic          hit_touch, touch, touch_rob;
    logic [SW-1:0] us;
    logic [WW-1:0] uw;
    logic [RAW-1:0] rlw;
    logic [FAW-1:0] flw;

    always_comb begin
        hit_touch = accept && ((kind == K_RD_HIT) || (kind == K_WR_HIT && way_rob));
        touch     = hit_touch || fill_valid;
        us        = fill_valid ? fill_set : req_set;
        uw        = fill_valid ? fill_way : req_way;
        touch_rob = (uw < WW'(N_ROB));
        rlw       = RAW'(uw);
        flw       = FAW'(uw - WW'(N_ROB));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                dty_q[s] <= '0;
                for (int i = 0; i < N_ROB; i++) rage_q[s][i*RAW +: RAW] <= RAW'(i);
                for (int i = 0; i < N_FRG; i++) fage_q[s][i*FAW +: FAW] <= FAW'(i);
            end
        end else begin
            if (fill_valid) begin
                vld_q[fill_set][fill_way] <= 1'b1;
                dty_q[fill_set][fill_way] <= fill_dirty;
            end else if (hit_touch && kind == K_WR_HIT) begin
                dty_q[req_set][req_way] <= 1'b1;
            end
            if (touch && touch_rob) begin
                for (int i = 0; i < N_ROB; i++) begin
                    if (RAW'(i) == rlw)
                        rage_q[us][i*RAW +: RAW] <= '0;
                    else if (rage_q[us][i*RAW +: RAW] < rage_q[us][rlw*RAW +: RAW])
                        rage_q[us][i*RAW +: RAW] <= rage_q[us][i*RAW +: RAW] + 1'b1;
                end
            end
            if (touch && !touch_rob) begin
                for (int i = 0; i < N_FRG; i++) begin
                    if (FAW'(i) == flw)
                        fage_q[us][i*FAW +: FAW] <= '0;
                    else if (fage_q[us][i*FAW +: FAW] < fage_q[us][flw*FAW +: FAW])
                        fage_q[us][i*FAW +: FAW] <= fage_q[us][i*FAW +: FAW] + 1'b1;
                end
            end
        end
    end

    a_r1_dirty_fill_robust: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_dirty) |-> (fill_way < WW'(N_ROB)));
    a_r2_clean_fill_fragile: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !fill_dirty) |-> (fill_way >= WW'(N_ROB)));
    a_r9_no_accept_in_fill: assert property (@(posedge clk) disable iff (rst)
        (fill_valid || wb_req) |-> !req_ready);
    a_r7_wb_only_robust: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> (wb_way < WW'(N_ROB)));
endmodule

// File: tb/mrw_alloc_ctrl_bench.sv
module mrw_alloc_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [3:0] req_set = '0;
    logic [2:0] req_way = '0;
    logic       req_ready, wb_req, wb_ack = 1'b0, fill_valid, fill_dirty;
    logic [2:0] wb_way, fill_way;
    logic [3:0] fill_set;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    mrw_alloc_ctrl u_mrw_alloc_ctrl (
        .clk, .rst, .req_valid, .req_kind, .req_set, .req_way, .req_ready,
        .wb_req, .wb_way, .wb_ack, .fill_valid, .fill_set, .fill_way, .fill_dirty
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // miss with expected victim; hold = extra cycles before wb_ack
    task automatic do_miss(input bit wr, input int set, input int exp_way,
                           input bit exp_wb, input int hold, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_kind = wr ? 2'd1 : 2'd0; req_set = 4'(set);
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_wb) begin
            chk(wb_req == 1'b1, {req, " wb_req"}, int'(wb_req), 1);
            chk(wb_way == 3'(exp_way), {req, " wb_way"}, int'(wb_way), exp_way);
            for (int k = 0; k < hold; k++) begin
                @(negedge clk);
                chk(wb_req && wb_way == 3'(exp_way) && !fill_valid && !req_ready,
                    "R7 wb held", int'(wb_req), 1);
            end
            wb_ack = 1'b1;
            @(negedge clk);
            wb_ack = 1'b0;
        end else begin
            chk(wb_req == 1'b0, {req, " R8 no wb"}, int'(wb_req), 0);
        end
        chk(fill_valid == 1'b1, {req, " fill_valid"}, int'(fill_valid), 1);
        chk(fill_way == 3'(exp_way), {req, " fill_way"}, int'(fill_way), exp_way);
        chk(fill_dirty == wr, {req, " fill_dirty"}, int'(fill_dirty), int'(wr));
        chk(fill_set == 4'(set), {req, " R10 fill_set"}, int'(fill_set), set);
        @(negedge clk);
        chk(!fill_valid && req_ready, {req, " R8 pulse ends"}, int'(fill_valid), 0);
    endtask

    task automatic do_hit(input bit wr, input int set, input int way);
        @(negedge clk);
        req_valid = 1'b1; req_kind = wr ? 2'd3 : 2'd2;
        req_set = 4'(set); req_way = 3'(way);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!fill_valid && !wb_req && req_ready, "R5 hit no fill", int'(fill_valid), 0);
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R9 reset ready", int'(req_ready), 1);
        chk(wb_req == 1'b0, "R9 reset wb_req", int'(wb_req), 0);
        chk(fill_valid == 1'b0, "R9 reset fill", int'(fill_valid), 0);
    endtask

    task automatic t_fill_fragile;
        for (int w = 2; w < 8; w++) do_miss(1'b0, 0, w, 1'b0, 0, "R2 R3 read fill");
    endtask

    task automatic t_fill_robust;
        do_miss(1'b1, 0, 0, 1'b0, 0, "R1 R3 write fill");
        do_miss(1'b1, 0, 1, 1'b0, 0, "R1 R3 write fill");
        do_miss(1'b1, 0, 0, 1'b1, 0, "R4 R7 robust lru");
    endtask

    task automatic t_read_hit_robust;
        do_hit(1'b0, 0, 1);                 // way 0 becomes LRU
        do_miss(1'b1, 0, 0, 1'b1, 0, "R5 read hit recency");
    endtask

    task automatic t_fragile_lru;
        do_hit(1'b0, 0, 2);                 // order oldest: 3,4,5,6,7,2
        do_miss(1'b0, 0, 3, 1'b0, 0, "R4 R5 fragile lru");
        do_hit(1'b1, 0, 4);                 // R6: must be ignored
        do_miss(1'b0, 0, 4, 1'b0, 0, "R6 fragile write hit ignored");
    endtask

    task automatic t_write_hit_robust;
        do_miss(1'b1, 1, 0, 1'b0, 0, "R1 set1");
        do_miss(1'b1, 1, 1, 1'b0, 0, "R1 set1");
        do_hit(1'b1, 1, 0);                 // way 1 becomes LRU
        do_miss(1'b1, 1, 1, 1'b1, 0, "R6 robust write hit");
    endtask

    task automatic t_sets;
        do_miss(1'b0, 2, 2, 1'b0, 0, "R10 set2 independent");
        do_miss(1'b1, 15, 0, 1'b0, 0, "R10 last set");
    endtask

    task automatic t_busy;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd1; req_set = 4'd0;
        @(negedge clk);
        req_kind = 2'd0; req_set = 4'd3;    // offered while busy: ignored
        chk(wb_req && wb_way == 3'd1 && !req_ready, "R7 R9 busy wb", int'(wb_way), 1);
        repeat (3) begin
            @(negedge clk);
            chk(wb_req && !fill_valid, "R7 wb held", int'(wb_req), 1);
        end
        req_valid = 1'b0;
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
        chk(fill_valid && fill_way == 3'd1 && fill_dirty, "R7 fill after ack", int'(fill_way), 1);
        @(negedge clk);
        do_miss(1'b0, 3, 2, 1'b0, 0, "R9 busy request ignored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill_fragile();
        t_fill_robust();
        t_read_hit_robust();
        t_fragile_lru();
        t_write_hit_robust();
        t_sets();
        t_busy();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule